// File: doc/BRIEF.md
# Page-Load Write Buffer with Idle-Gap Commit

This block is a clocked model of the write side of a byte-wide, page-programmed nonvolatile store. A host bus presents an address, a data byte and three active-low controls: select, write strobe and output gate. Each qualified byte strobe deposits one byte into a page-sized holding buffer. The first accepted byte opens a page, and the buffer is preset to all ones (FFh) at that moment. Later bytes for the same page may arrive in any order.

No explicit command starts programming. Once the bus has been quiet for a parameterised number of cycles after the most recent accepted byte, the whole page is copied into the backing register file in one cycle. Every position the host did not fill is stored as FFh. The block then reports busy for a fixed programming time. Strobes that arrive while busy are dropped. A strobe aimed at a page other than the open one is dropped and sets a sticky error flag.

The same pins also read the backing store, so the host can check committed contents. Timeout, programming time and the minimum strobe length are all given in clock cycles.

Top module: `page_load_buffer`

## Requirements
- R1: After reset every location of the backing store reads FFh, `busy` is 0 and `page_err` is 0.
- R2: A byte strobe is active only while `sel_n`=0, `wstb_n`=0 and `oen_n`=1. If `oen_n` is low during the strobe, the strobe has no effect: no page opens and the store is unchanged.
- R3: The address comes from the first active cycle of a strobe. The data byte comes from the last active cycle before the strobe ends.
- R4: A strobe with fewer than GLITCH_CYC active cycles loads nothing.
- R5: Within an open page, bytes may be loaded in any order. A repeated offset keeps the last byte written to it.
- R6: Programming starts once TIMEOUT_CYC cycles pass with no accepted byte. Each accepted byte restarts that window, so `busy` stays 0 while loads keep arriving inside it.
- R7: A commit writes all 2^OFS_W bytes of the page at once. Offsets not loaded since the page opened become FFh, even if they held other data before.
- R8: `busy` stays high for PROG_CYC cycles after a commit. Strobes during that time are ignored.
- R9: A strobe whose page number (addr bits above OFS_W) differs from the open page is ignored and sets `page_err`. `page_err` then stays set until reset.
- R10: When `sel_n`=0, `oen_n`=0 and `wstb_n`=1, `rdata` shows the stored byte at `addr`. Otherwise `rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low device select |
| wstb_n | input | 1 | Active-low write strobe |
| oen_n | input | 1 | Active-low output gate |
| addr | input | ADDR_W | Byte address; upper bits page, low OFS_W bits offset |
| wdata | input | 8 | Byte to load |
| rdata | output | 8 | Stored byte during a read, else 00h |
| busy | output | 1 | Internal programming in progress |
| page_err | output | 1 | Sticky flag for a strobe aimed at the wrong page |

## Verification
The bench builds the block with ADDR_W=10, TIMEOUT_CYC=16, PROG_CYC=40 and GLITCH_CYC=3. With these short timings, the exact edges of the idle window and the busy period can be checked within a few cycles. Several pages can be opened, committed and reprogrammed within the run. A strobe of two active cycles sits just under the glitch threshold and one of three sits exactly on it, so both sides of the threshold are tested.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgl_state_e;

  // counter width able to hold 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pgl_strobe.sv
module pgl_strobe #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              oen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_act,
  output logic              ld_stb,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data
);
  localparam int unsigned CW = pgl_pkg::cnt_w(GLITCH_CYC);
  localparam logic [CW-1:0] RUN_MAX = CW'(GLITCH_CYC);

  logic          act_q;
  logic [CW-1:0] run;

  assign wr_act = !sel_n && !wstb_n && oen_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      run     <= '0;
      ld_stb  <= 1'b0;
      ld_addr <= '0;
      ld_data <= 8'h00;
    end else begin
      act_q  <= wr_act;
      ld_stb <= 1'b0;
      if (wr_act && !act_q) begin
        ld_addr <= addr;
        run     <= CW'(1);
      end else if (wr_act && run != RUN_MAX) begin
        run <= run + CW'(1);
      end
      if (wr_act) ld_data <= wdata;
      if (!wr_act && act_q) begin
        ld_stb <= (run >= RUN_MAX);
        run    <= '0;
      end
    end
  end
endmodule

// File: rtl/pgl_ctrl.sv
module pgl_ctrl #(
  parameter int unsigned PAGE_W      = 3,
  parameter int unsigned TIMEOUT_CYC = 10000,
  parameter int unsigned PROG_CYC    = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [PAGE_W-1:0] ld_page,
  output logic              buf_open,
  output logic              buf_wr,
  output logic              commit,
  output logic              busy,
  output logic              page_err,
  output logic [PAGE_W-1:0] open_page
);
  import pgl_pkg::*;
  localparam int unsigned TW = cnt_w(TIMEOUT_CYC);
  localparam int unsigned PW = cnt_w(PROG_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PROG_CYC - 1);

  pgl_state_e    state;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pcnt;
  logic          same_page;
  logic          mismatch;

  assign same_page = (ld_page == open_page);
  assign buf_open  = ld_stb && (state == ST_IDLE);
  assign buf_wr    = ld_stb && ((state == ST_IDLE) || ((state == ST_LOAD) && same_page));
  assign mismatch  = ld_stb && (state == ST_LOAD) && !same_page;
  assign commit    = (state == ST_LOAD) && !buf_wr && (tmr == T_LAST);
  assign busy      = (state == ST_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      pcnt      <= '0;
      page_err  <= 1'b0;
      open_page <= '0;
    end else begin
      if (mismatch) page_err <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (buf_open) begin
            open_page <= ld_page;
            tmr       <= '0;
            state     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (buf_wr) begin
            tmr <= '0;
          end else if (commit) begin
            pcnt  <= '0;
            state <= ST_PROG;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_PROG: begin
          if (pcnt == P_LAST) state <= ST_IDLE;
          else                pcnt  <= pcnt + PW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgl_pagebuf.sv
module pgl_pagebuf #(
  parameter int unsigned OFS_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr,
  input  logic [OFS_W-1:0]            ofs,
  input  logic [7:0]                  data,
  output logic [(2**OFS_W)*8-1:0]     page_bytes
);
  localparam int unsigned NB = 2 ** OFS_W;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic hit;
    assign hit = wr && (ofs == OFS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   page_bytes[g*8 +: 8] <= 8'hFF;
      else if (hit) page_bytes[g*8 +: 8] <= data;
      else if (clr) page_bytes[g*8 +: 8] <= 8'hFF;
    end
  end
endmodule

// File: rtl/pgl_array.sv
module pgl_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OFS_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [ADDR_W-OFS_W-1:0]  page,
  input  logic [(2**OFS_W)*8-1:0]  page_bytes,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_byte
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;
  localparam int unsigned NB    = 2 ** OFS_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < NB; i++) mem[{page, OFS_W'(i)}] <= page_bytes[i*8 +: 8];
    end
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned OFS_W       = 7,
  parameter int unsigned TIMEOUT_CYC = 10000,
  parameter int unsigned PROG_CYC    = 500000,
  parameter int unsigned GLITCH_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              oen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy,
  output logic              page_err
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam int unsigned NB     = 2 ** OFS_W;

  logic              wr_act;
  logic              ld_stb;
  logic [ADDR_W-1:0] ld_addr;
  logic [7:0]        ld_data;
  logic              buf_open;
  logic              buf_wr;
  logic              commit;
  logic [PAGE_W-1:0] open_page;
  logic [NB*8-1:0]   page_bytes;
  logic [7:0]        rd_raw;
  logic              rd_en;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  pgl_strobe #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_stb (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .oen_n(oen_n),
    .addr(addr), .wdata(wdata), .wr_act(wr_act), .ld_stb(ld_stb),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  pgl_ctrl #(.PAGE_W(PAGE_W), .TIMEOUT_CYC(TIMEOUT_CYC), .PROG_CYC(PROG_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_page(page_of(ld_addr)),
    .buf_open(buf_open), .buf_wr(buf_wr), .commit(commit), .busy(busy),
    .page_err(page_err), .open_page(open_page)
  );

  pgl_pagebuf #(.OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_open), .wr(buf_wr),
    .ofs(ofs_of(ld_addr)), .data(ld_data), .page_bytes(page_bytes)
  );

  pgl_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(open_page),
    .page_bytes(page_bytes), .rd_addr(addr), .rd_byte(rd_raw)
  );

  assign rd_en = !sel_n && !oen_n && wstb_n;
  assign rdata = rd_en ? rd_raw : 8'h00;
endmodule

// File: rtl/page_load_buffer_chk.sv
module page_load_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_stb,
  input logic       buf_open,
  input logic       buf_wr,
  input logic       commit,
  input logic       busy,
  input logic       page_err,
  input logic       rd_en,
  input logic [7:0] rdata
);
  AST_ERR_STICKY:      assert property (@(posedge clk) disable iff (!rst_n) page_err |=> page_err); // R9
  AST_COMMIT_TO_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) commit |=> busy); // R6
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(commit)); // R8
  AST_NO_LOAD_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) busy |-> !buf_wr); // R8
  AST_SINGLE_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) ld_stb |-> !$past(ld_stb)); // R4
  AST_OPEN_NOT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({buf_open, commit})); // R6
  AST_QUIET_BUS:       assert property (@(posedge clk) disable iff (!rst_n) !rd_en |-> rdata == 8'h00); // R10
endmodule

bind page_load_buffer page_load_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .buf_open(buf_open), .buf_wr(buf_wr),
  .commit(commit), .busy(busy), .page_err(page_err), .rd_en(rd_en), .rdata(rdata)
);

// File: tb/page_load_buffer_test.sv
module page_load_buffer_test;
  localparam int AW = 10;
  localparam int TO = 16;
  localparam int PG = 40;
  localparam int GL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, wstb_n = 1'b1, oen_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic busy, page_err;

  int total = 0;
  int fails = 0;

  logic [7:0] model [1024];
  logic [7:0] pbuf [128];

  always #2 clk = ~clk;

  page_load_buffer #(.ADDR_W(AW), .OFS_W(7), .TIMEOUT_CYC(TO), .PROG_CYC(PG),
                     .GLITCH_CYC(GL)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .oen_n(oen_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .page_err(page_err)
  );

  // {addr, data}: page 2, scattered offsets, one repeated offset
  localparam logic [17:0] LD_TBL [8] = '{
    {10'h145, 8'hA1}, {10'h103, 8'h3C}, {10'h17F, 8'h7E}, {10'h100, 8'h01},
    {10'h120, 8'hC4}, {10'h166, 8'h99}, {10'h103, 8'h5D}, {10'h111, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    addr = a; wdata = d; sel_n = 1'b0; wstb_n = 1'b0; oen_n = 1'b1;
    cyc(len);
    wstb_n = 1'b1; sel_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; sel_n = 1'b0; oen_n = 1'b0; wstb_n = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    sel_n = 1'b1; oen_n = 1'b1;
  endtask

  task automatic m_open();
    for (int i = 0; i < 128; i++) pbuf[i] = 8'hFF;
  endtask

  task automatic m_commit(input int page);
    for (int i = 0; i < 128; i++) model[page*128 + i] = pbuf[i];
  endtask

  task automatic settle();
    cyc(TO + PG + 10);
  endtask

  task automatic check_page(input string tag, input int page);
    logic [7:0] v;
    for (int i = 0; i < 128; i++) begin
      rd(AW'(page*128 + i), v);
      chk(tag, v, model[page*128 + i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 page_err", page_err, 0);
    rd(10'h000, v); chk("R1 read low", v, 8'hFF);
    rd(10'h3FF, v); chk("R1 read high", v, 8'hFF);
    // R10 idle bus reads zero
    #1 chk("R10 idle rdata", rdata, 8'h00);

    // R5 table walk: out-of-order loads in page 2
    m_open();
    for (int k = 0; k < 8; k++) begin
      load(LD_TBL[k][17:8], LD_TBL[k][7:0], 4);
      pbuf[LD_TBL[k][14:8]] = LD_TBL[k][7:0];
      chk("R6 busy during loads", busy, 0);
    end
    // R6 window edges
    cyc(TO - 3); chk("R6 busy before timeout", busy, 0);
    cyc(6);      chk("R6 busy after timeout", busy, 1);
    m_commit(2);
    // R8 load during busy is dropped
    load(10'h110, 8'h77, 4);
    cyc(PG - 15); chk("R8 busy held", busy, 1);
    cyc(20);      chk("R8 busy released", busy, 0);
    chk("R8 no new page opened", busy, 0);
    check_page("R5 R7 page2 contents", 2);
    rd(10'h180, v); chk("R7 neighbour page untouched", v, 8'hFF);

    // R9 wrong-page load
    m_open();
    load(10'h281, 8'h11, 4); pbuf[1] = 8'h11;
    load(10'h301, 8'h22, 4);
    cyc(2); chk("R9 err set", page_err, 1);
    settle();
    m_commit(5);
    rd(10'h281, v); chk("R9 open page byte", v, 8'h11);
    rd(10'h301, v); chk("R9 foreign byte dropped", v, 8'hFF);
    chk("R9 err sticky", page_err, 1);

    // R4 glitch filter: 2 active cycles dropped, 3 accepted
    load(10'h200, 8'h5A, 2);
    cyc(TO + 6); chk("R4 short strobe no busy", busy, 0);
    rd(10'h200, v); chk("R4 short strobe no data", v, 8'hFF);
    m_open();
    load(10'h200, 8'h5B, 3); pbuf[0] = 8'h5B;
    settle(); m_commit(4);
    rd(10'h200, v); chk("R4 threshold strobe loads", v, 8'h5B);

    // R2 output gate low inhibits
    @(negedge clk);
    addr = 10'h042; wdata = 8'h42; sel_n = 1'b0; wstb_n = 1'b0; oen_n = 1'b0;
    cyc(5);
    wstb_n = 1'b1; sel_n = 1'b1; oen_n = 1'b1;
    cyc(TO + 6); chk("R2 inhibited no busy", busy, 0);
    rd(10'h042, v); chk("R2 inhibited no data", v, 8'hFF);

    // R3 address from first cycle, data from last
    @(negedge clk);
    addr = 10'h0A0; wdata = 8'h10; sel_n = 1'b0; wstb_n = 1'b0; oen_n = 1'b1;
    @(negedge clk); addr = 10'h0B0; wdata = 8'h20;
    @(negedge clk); wdata = 8'h30;
    @(negedge clk); wdata = 8'h3E;
    @(negedge clk); wstb_n = 1'b1; sel_n = 1'b1; wdata = 8'hEE;
    m_open(); pbuf[7'h20] = 8'h3E;
    settle(); m_commit(1);
    rd(10'h0A0, v); chk("R3 first-cycle address last data", v, 8'h3E);
    rd(10'h0B0, v); chk("R3 later address unused", v, 8'hFF);

    // R7 reprogram page 2 with one byte: rest becomes FF
    m_open();
    load(10'h150, 8'h6C, 4); pbuf[7'h50] = 8'h6C;
    settle(); m_commit(2);
    rd(10'h150, v); chk("R7 new byte", v, 8'h6C);
    rd(10'h145, v); chk("R7 old byte erased", v, 8'hFF);
    rd(10'h103, v); chk("R7 old byte erased 2", v, 8'hFF);

    // R6 window restart: loads spaced inside timeout
    m_open();
    load(10'h381, 8'hB1, 3); pbuf[1] = 8'hB1;
    cyc(TO - 9); chk("R6 restart gap1", busy, 0);
    load(10'h382, 8'hB2, 3); pbuf[2] = 8'hB2;
    cyc(TO - 9); chk("R6 restart gap2", busy, 0);
    load(10'h383, 8'hB3, 3); pbuf[3] = 8'hB3;
    cyc(TO - 9); chk("R6 restart gap3", busy, 0);
    settle(); m_commit(7);
    rd(10'h381, v); chk("R6 byte1", v, 8'hB1);
    rd(10'h382, v); chk("R6 byte2", v, 8'hB2);
    rd(10'h383, v); chk("R6 byte3", v, 8'hB3);

    // R10 output gate high: no data driven
    @(negedge clk);
    addr = 10'h381; sel_n = 1'b0; oen_n = 1'b1; wstb_n = 1'b1;
    #1 chk("R10 gate high rdata", rdata, 8'h00);
    @(negedge clk); sel_n = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule